// File: doc/BRIEF.md
# Programmable Interval Timer

This block holds three identical 16-bit down-counters that share one 8-bit register port. A 2-bit address picks a port. Addresses 0, 1 and 2 are the data ports of the channels. Address 3 is a shared configuration port. A byte written to the configuration port chooses a channel and sets four things for it: its count format (binary or decimal), its output behaviour, and how 16-bit values move across the 8-bit bus. The same byte can instead freeze the channel's current count for a later read. Data writes then load the starting count, and data reads return the count.

Each channel has a count-enable input and a gate input, and drives one output. The count-enable input is a clock enable that marks a counting cycle, called a tick. Bus accesses and counting share `clk`. Each channel runs a state machine with five states:

- `ST_IDLE`: waiting for a count after configuration.
- `ST_ARMED`: count loaded, waiting for a gate rising edge.
- `ST_RUN`: counting.
- `ST_STROBE`: output pulse low for one tick.
- `ST_DONE`: terminal count reached, counting stopped.

The state machine moves between these states as follows:

- Any accepted configuration goes to `ST_IDLE`.
- A completed load goes to `ST_ARMED` in modes 1 and 5, and to `ST_RUN` in the other modes.
- In modes 1 and 5, a gate rising edge in any state except `ST_IDLE` reloads the count and goes to `ST_RUN`.
- From `ST_RUN`, reaching zero goes to `ST_DONE` in mode 0, `ST_ARMED` in mode 1, and `ST_STROBE` in modes 4 and 5.
- From `ST_STROBE`, the next tick goes to `ST_DONE` in mode 4 and `ST_ARMED` in mode 5.

Modes 2 and 3 reload themselves and stay in `ST_RUN`.

Top module: `pit_timer`

## Requirements
- R1: The configuration byte has four fields. Bit 0 selects decimal counting when 1. Bits 3:1 hold the mode. Bits 5:4 hold the access type. Bits 7:6 hold the channel. A byte whose channel field is 3 has no effect at all. A byte with mode code 6 or 7 and a nonzero access type also has no effect at all.
- R2: An accepted configuration takes effect at the next edge. It stops counting until a full new count is loaded and resets the byte order for writes and reads. It drops any frozen count. It drives the output to the mode's idle level: low for mode 0, high for the other modes.
- R3: Access type 1 loads the written byte as the low byte with a zero high byte. Access type 2 loads the byte as the high byte with a zero low byte. Access type 3 takes the low byte and then the high byte, and the load completes on the second write. A completed load sets the count at that edge.
- R4: Access type 0 freezes the current count, and data reads return the frozen value in the channel's byte order until all of its bytes have been read. The running count is unaffected. A freeze request while a frozen value is still unread is ignored.
- R5: In mode 0, the output is low after loading and goes high on the N-th tick after a load of N. It then stays high and counting stops.
- R6: In mode 1, a loaded channel waits for a gate rising edge. At the edge after the rise, the output goes low and the count reloads. The output returns high on the N-th following tick. Every later rise triggers the sequence again.
- R7: In mode 2, the output is low for exactly one tick out of every N ticks: it goes low on tick N-1 and high again on tick N, when the count reloads.
- R8: In mode 3, the period is N ticks. The output is high for N - floor(N/2) ticks and then low for floor(N/2) ticks.
- R9: In mode 4, on the N-th tick after loading, the output goes low for one tick. It then stays high and counting stops.
- R10: In mode 5, counting starts only at a gate rising edge. On the N-th tick after that edge the output goes low for one tick. A later rise starts the sequence again.
- R11: The count changes only on ticks. In modes 0, 2, 3 and 4 a tick also needs the gate to be high.
- R12: In decimal format, each 4-bit digit counts down from 9 to 0 with a borrow into the next digit. A loaded zero means 65536 ticks in binary and 10000 ticks in decimal.
- R13: After reset, every channel is in mode 0 with single low-byte access and binary format. Every count is zero, every output is low, and reads of every port return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counters |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Port select: 0 to 2 are channel data ports, 3 is the configuration port |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe; the read side effect happens at the clock edge |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for the addressed port |
| count_en | input | 3 | Tick enable for each channel |
| gate_in | input | 3 | Gate input for each channel |
| timer_out | output | 3 | Output of each channel |

## Verification
The bench builds the timer with its default parameters: three channels of 16 bits on an 8-bit bus. These defaults put the full-range terminal counts within reach: a loaded zero runs 65536 ticks in binary and 10000 ticks in decimal. Random lengths, channels and formats drive the periodic modes, and the bench measures the high and low durations of the output. Directed sequences cover the two gate-triggered modes, the frozen-count read of a decimal count part way through a run, and configuration bytes that must be dropped.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        ACC_FREEZE = 2'd0,
        ACC_LO     = 2'd1,
        ACC_HI     = 2'd2,
        ACC_WORD   = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        MD_TERM    = 3'd0,
        MD_ONESHOT = 3'd1,
        MD_RATE    = 3'd2,
        MD_SQUARE  = 3'd3,
        MD_SWSTB   = 3'd4,
        MD_HWSTB   = 3'd5
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_RUN,
        ST_STROBE,
        ST_DONE
    } state_e;

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode #(
    parameter int CH_N = 3,
    parameter int AW   = 2
) (
    input  logic [AW-1:0]   addr,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      sel,
    input  logic [1:0]      acc,
    input  logic [2:0]      mode,
    output logic [CH_N-1:0] cw_wr,
    output logic [CH_N-1:0] freeze_req,
    output logic [CH_N-1:0] data_wr,
    output logic [CH_N-1:0] data_rd
);
    localparam logic [AW-1:0] CW_ADDR = AW'(CH_N);

    logic cfg_access;
    logic mode_legal;

    assign cfg_access = wr_en && (addr == CW_ADDR);
    assign mode_legal = (mode < 3'd6);

    for (genvar g = 0; g < CH_N; g++) begin : g_dec
        logic hit;
        assign hit           = cfg_access && (sel == 2'(g));
        assign cw_wr[g]      = hit && mode_legal && (acc != 2'd0);
        assign freeze_req[g] = hit && (acc == 2'd0);
        assign data_wr[g]    = wr_en && (addr == AW'(g));
        assign data_rd[g]    = rd_en && (addr == AW'(g));
    end

endmodule

// File: rtl/pit_byte_seq.sv
module pit_byte_seq
    import pit_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cw_wr,
    input  logic [1:0]       cw_acc,
    input  logic             freeze_req,
    input  logic             data_wr,
    input  logic             data_rd,
    input  logic [DW-1:0]    wbyte,
    input  logic [CNT_W-1:0] cnt_now,
    output logic             load_pulse,
    output logic [CNT_W-1:0] init_val,
    output logic [DW-1:0]    rbyte
);
    acc_e             acc_q;
    logic             wr_hi_q;
    logic             rd_hi_q;
    logic             frozen_q;
    logic [CNT_W-1:0] hold_q;
    logic [DW-1:0]    lo_buf_q;
    logic [CNT_W-1:0] rd_src;
    logic             rd_last;

    // a read is the last one of its value when the access is single-byte or the high half of a pair
    assign rd_last = (acc_q != ACC_WORD) || rd_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= ACC_LO;
            wr_hi_q  <= 1'b0;
            rd_hi_q  <= 1'b0;
            frozen_q <= 1'b0;
            hold_q   <= '0;
            lo_buf_q <= '0;
        end else if (cw_wr) begin
            acc_q    <= acc_e'(cw_acc);
            wr_hi_q  <= 1'b0;
            rd_hi_q  <= 1'b0;
            frozen_q <= 1'b0;
        end else begin
            if (freeze_req && !frozen_q) begin
                frozen_q <= 1'b1;
                hold_q   <= cnt_now;
            end
            if (data_wr && (acc_q == ACC_WORD)) begin
                if (!wr_hi_q) begin
                    lo_buf_q <= wbyte;
                    wr_hi_q  <= 1'b1;
                end else begin
                    wr_hi_q  <= 1'b0;
                end
            end
            if (data_rd) begin
                if (acc_q == ACC_WORD) begin
                    rd_hi_q <= !rd_hi_q;
                end
                if (rd_last) begin
                    frozen_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        load_pulse = data_wr && ((acc_q != ACC_WORD) || wr_hi_q);
        unique case (acc_q)
            ACC_HI:   init_val = {wbyte, {DW{1'b0}}};
            ACC_WORD: init_val = {wbyte, lo_buf_q};
            default:  init_val = {{DW{1'b0}}, wbyte};
        endcase
    end

    always_comb begin
        rd_src = frozen_q ? hold_q : cnt_now;
        unique case (acc_q)
            ACC_HI:   rbyte = rd_src[CNT_W-1:DW];
            ACC_WORD: rbyte = rd_hi_q ? rd_src[CNT_W-1:DW] : rd_src[DW-1:0];
            default:  rbyte = rd_src[DW-1:0];
        endcase
    end

    AST_FREEZE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen_q && !cw_wr && !data_rd) |=> (frozen_q && $stable(hold_q))); // R4

endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cw_wr,
    input  logic [2:0]       cw_mode,
    input  logic             cw_bcd,
    input  logic             load_pulse,
    input  logic [CNT_W-1:0] init_val,
    input  logic             tick,
    input  logic             gate,
    output logic [CNT_W-1:0] cnt_q,
    output logic             out_q
);
    localparam int               DIGITS = CNT_W / 4;
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    function automatic logic [CNT_W-1:0] count_dec(input logic [CNT_W-1:0] v, input logic dec_fmt);
        logic [CNT_W-1:0] r;
        logic             borrow;
        r      = v;
        borrow = 1'b1;
        if (!dec_fmt) begin
            r = v - ONE;
        end else begin
            for (int d = 0; d < DIGITS; d++) begin
                if (borrow) begin
                    if (r[d*4 +: 4] == 4'd0) begin
                        r[d*4 +: 4] = 4'd9;
                    end else begin
                        r[d*4 +: 4] = r[d*4 +: 4] - 4'd1;
                        borrow      = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] count_half(input logic [CNT_W-1:0] v, input logic dec_fmt);
        logic [CNT_W-1:0] r;
        logic             carry;
        logic [4:0]       part;
        r     = '0;
        carry = 1'b0;
        if (v == '0) begin
            r = dec_fmt ? (CNT_W'(5) << (CNT_W - 4)) : (ONE << (CNT_W - 1));
        end else if (!dec_fmt) begin
            r = v >> 1;
        end else begin
            for (int d = DIGITS - 1; d >= 0; d--) begin
                part        = 5'(v[d*4 +: 4]) + (carry ? 5'd10 : 5'd0);
                r[d*4 +: 4] = part[4:1];
                carry       = part[0];
            end
        end
        return r;
    endfunction

    state_e           state_q, state_d;
    mode_e            mode_q;
    logic             bcd_q;
    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] half_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] nxt;
    logic             out_d;
    logic             gate_q;
    logic             gate_rise;
    logic             trig_mode;
    logic             retrig;
    logic             advance;

    assign nxt       = count_dec(cnt_q, bcd_q);
    assign gate_rise = gate && !gate_q;
    assign trig_mode = (mode_q == MD_ONESHOT) || (mode_q == MD_HWSTB);
    assign retrig    = trig_mode && gate_rise && (state_q != ST_IDLE);
    assign advance   = tick && (trig_mode || gate);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            out_q   <= 1'b0;
            gate_q  <= 1'b0;
            mode_q  <= MD_TERM;
            bcd_q   <= 1'b0;
            init_q  <= '0;
            half_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            out_q   <= out_d;
            gate_q  <= gate;
            if (cw_wr) begin
                mode_q <= mode_e'(cw_mode);
                bcd_q  <= cw_bcd;
            end else if (load_pulse) begin
                init_q <= init_val;
                half_q <= count_half(init_val, bcd_q);
            end
        end
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (cw_wr) begin
            state_d = ST_IDLE;
        end else if (load_pulse) begin
            cnt_d   = init_val;
            state_d = trig_mode ? ST_ARMED : ST_RUN;
        end else if (retrig) begin
            cnt_d   = init_q;
            state_d = ST_RUN;
        end else if (advance) begin
            unique case (state_q)
                ST_RUN: begin
                    case (mode_q)
                        MD_RATE:   cnt_d = (cnt_q == ONE) ? init_q : nxt;
                        MD_SQUARE: cnt_d = (nxt == '0) ? init_q : nxt;
                        MD_TERM: begin
                            cnt_d = nxt;
                            if (nxt == '0) state_d = ST_DONE;
                        end
                        MD_ONESHOT: begin
                            cnt_d = nxt;
                            if (nxt == '0) state_d = ST_ARMED;
                        end
                        default: begin
                            cnt_d = nxt;
                            if (nxt == '0) state_d = ST_STROBE;
                        end
                    endcase
                end
                ST_STROBE: state_d = (mode_q == MD_HWSTB) ? ST_ARMED : ST_DONE;
                default: ;
            endcase
        end
    end

    // output level
    always_comb begin
        out_d = out_q;
        if (cw_wr) begin
            out_d = (cw_mode != 3'd0);
        end else if (load_pulse) begin
            out_d = (mode_q != MD_TERM);
        end else if (retrig) begin
            out_d = (mode_q != MD_ONESHOT);
        end else if (advance) begin
            unique case (state_q)
                ST_RUN: begin
                    case (mode_q)
                        MD_TERM, MD_ONESHOT: begin
                            if (nxt == '0) out_d = 1'b1;
                        end
                        MD_RATE: begin
                            if (nxt == ONE) out_d = 1'b0;
                            else if (cnt_q == ONE) out_d = 1'b1;
                        end
                        MD_SQUARE: begin
                            if (nxt == '0) out_d = 1'b1;
                            else if (nxt == half_q) out_d = 1'b0;
                        end
                        default: begin
                            if (nxt == '0) out_d = 1'b0;
                        end
                    endcase
                end
                ST_STROBE: out_d = 1'b1;
                default: ;
            endcase
        end
    end

    AST_CFG_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        cw_wr |=> (state_q == ST_IDLE && out_q == (mode_q != MD_TERM))); // R2
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !tick && !cw_wr && !load_pulse && !gate_rise) |=> $stable(cnt_q)); // R11
    AST_TERM_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_TERM && state_q == ST_RUN) |-> !out_q); // R5
    AST_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE) |-> !out_q); // R9

endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
    parameter int CH_N  = 3,
    parameter int CNT_W = 16,
    parameter int AW    = 2,
    parameter int DW    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [CH_N-1:0] count_en,
    input  logic [CH_N-1:0] gate_in,
    output logic [CH_N-1:0] timer_out
);
    logic [CH_N-1:0] cw_wr_v;
    logic [CH_N-1:0] freeze_v;
    logic [CH_N-1:0] dwr_v;
    logic [CH_N-1:0] drd_v;
    logic [DW-1:0]   rbyte [CH_N];

    pit_ctrl_decode #(
        .CH_N (CH_N),
        .AW   (AW)
    ) u_dec (
        .addr       (bus_addr),
        .wr_en      (bus_wr),
        .rd_en      (bus_rd),
        .sel        (bus_wdata[7:6]),
        .acc        (bus_wdata[5:4]),
        .mode       (bus_wdata[3:1]),
        .cw_wr      (cw_wr_v),
        .freeze_req (freeze_v),
        .data_wr    (dwr_v),
        .data_rd    (drd_v)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        logic             load_pulse;
        logic [CNT_W-1:0] init_val;
        logic [CNT_W-1:0] cnt_now;

        pit_byte_seq #(
            .CNT_W (CNT_W),
            .DW    (DW)
        ) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .cw_wr      (cw_wr_v[g]),
            .cw_acc     (bus_wdata[5:4]),
            .freeze_req (freeze_v[g]),
            .data_wr    (dwr_v[g]),
            .data_rd    (drd_v[g]),
            .wbyte      (bus_wdata),
            .cnt_now    (cnt_now),
            .load_pulse (load_pulse),
            .init_val   (init_val),
            .rbyte      (rbyte[g])
        );

        pit_count_core #(
            .CNT_W (CNT_W)
        ) u_core (
            .clk        (clk),
            .rst_n      (rst_n),
            .cw_wr      (cw_wr_v[g]),
            .cw_mode    (bus_wdata[3:1]),
            .cw_bcd     (bus_wdata[0]),
            .load_pulse (load_pulse),
            .init_val   (init_val),
            .tick       (count_en[g]),
            .gate       (gate_in[g]),
            .cnt_q      (cnt_now),
            .out_q      (timer_out[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < CH_N; g++) begin
            if (bus_addr == AW'(g)) bus_rdata = rbyte[g];
        end
    end

    AST_CFG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cw_wr_v | freeze_v)); // R1
    AST_BAD_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(CH_N) && bus_wdata[7:6] == 2'b11) |-> (cw_wr_v == '0 && freeze_v == '0)); // R1

endmodule

// File: tb/pit_timer_test.sv
module pit_timer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr;
    logic       bus_wr;
    logic       bus_rd;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [2:0] count_en;
    logic [2:0] gate_in;
    logic [2:0] timer_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pit_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count_en  (count_en),
        .gate_in   (gate_in),
        .timer_out (timer_out)
    );

    function automatic int hi_ticks(input int n);
        return n - n / 2;
    endfunction

    function automatic int to_bcd(input int v);
        return ((v / 1000) % 10) * 4096 + ((v / 100) % 10) * 256 + ((v / 10) % 10) * 16 + (v % 10);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // each bus task spends exactly one clock edge and returns at a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic cfg(input int ch, input int acc, input int mode, input int bcd);
        wr(2'd3, {2'(ch), 2'(acc), 3'(mode), 1'(bcd)});
    endtask

    task automatic load_word(input int ch, input int v);
        wr(2'(ch), 8'(v));
        wr(2'(ch), 8'(v >> 8));
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_out(input int ch, input logic lvl, input int limit, output int n);
        n = 0;
        while (timer_out[ch] !== lvl && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n, d, lo;
        bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        count_en = 3'b111; gate_in = 3'b111;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        check("R13 outputs", int'(timer_out), 0);
        rd(2'd0, d);
        check("R13 read ch0", d, 0);

        // R5 mode 0 with a two-byte load
        cfg(0, 3, 0, 0);
        check("R2 mode0 idle low", int'(timer_out[0]), 0);
        load_word(0, 25);
        wait_out(0, 1'b1, 100, n);
        check("R5 mode0 terminal", n, 25);
        step(20);
        check("R5 mode0 stays high", int'(timer_out[0]), 1);

        // R4 / R12 freeze a decimal count part way through
        cfg(0, 3, 0, 1);
        load_word(0, 'h0100);
        step(30);
        wr(2'd3, 8'h00);
        step(5);
        rd(2'd0, d);
        check("R4 frozen low byte", d, 'h70);
        rd(2'd0, d);
        check("R4 frozen high byte", d, 'h00);
        wait_out(0, 1'b1, 200, n);
        check("R12 decimal remaining", n, 62);

        // R12 zero means full range
        cfg(1, 3, 0, 1);
        load_word(1, 0);
        wait_out(1, 1'b1, 20000, n);
        check("R12 decimal zero", n, 10000);
        cfg(2, 3, 0, 0);
        load_word(2, 0);
        wait_out(2, 1'b1, 70000, n);
        check("R12 binary zero", n, 65536);

        // R3 single-byte access types
        cfg(2, 1, 0, 0);
        wr(2'd2, 8'd9);
        wait_out(2, 1'b1, 100, n);
        check("R3 low byte only", n, 9);
        cfg(2, 2, 0, 0);
        wr(2'd2, 8'd1);
        wait_out(2, 1'b1, 400, n);
        check("R3 high byte only", n, 256);

        // R6 one-shot
        gate_in[0] = 1'b0;
        cfg(0, 3, 1, 0);
        check("R2 mode1 idle high", int'(timer_out[0]), 1);
        load_word(0, 12);
        step(5);
        check("R6 waits for gate", int'(timer_out[0]), 1);
        gate_in[0] = 1'b1;
        wait_out(0, 1'b0, 50, n);
        check("R6 low after rise", n, 1);
        wait_out(0, 1'b1, 50, n);
        check("R6 low width", n, 12);
        gate_in[0] = 1'b0;
        step(2);
        gate_in[0] = 1'b1;
        wait_out(0, 1'b0, 50, n);
        check("R6 retrigger", n, 1);
        wait_out(0, 1'b1, 50, n);
        check("R6 retrigger width", n, 12);

        // R10 hardware strobe
        gate_in[1] = 1'b0;
        cfg(1, 3, 5, 0);
        load_word(1, 8);
        step(4);
        check("R10 waits for gate", int'(timer_out[1]), 1);
        gate_in[1] = 1'b1;
        wait_out(1, 1'b0, 50, n);
        check("R10 strobe time", n, 9);
        wait_out(1, 1'b1, 50, n);
        check("R10 strobe width", n, 1);
        step(10);
        check("R10 no repeat without edge", int'(timer_out[1]), 1);
        gate_in[1] = 1'b0;
        step(1);
        gate_in[1] = 1'b1;
        wait_out(1, 1'b0, 50, n);
        check("R10 retrigger", n, 9);

        // R9 software strobe
        cfg(2, 3, 4, 0);
        load_word(2, 6);
        wait_out(2, 1'b0, 50, n);
        check("R9 strobe time", n, 6);
        wait_out(2, 1'b1, 50, n);
        check("R9 strobe width", n, 1);
        step(10);
        check("R9 single strobe", int'(timer_out[2]), 1);

        // R11 gate low and tick enable low both hold the count
        gate_in[0] = 1'b0;
        cfg(0, 3, 0, 0);
        load_word(0, 10);
        step(7);
        check("R11 gate low holds", int'(timer_out[0]), 0);
        gate_in[0] = 1'b1;
        wait_out(0, 1'b1, 50, n);
        check("R11 gate resume", n, 10);
        cfg(0, 3, 0, 0);
        count_en[0] = 1'b0;
        load_word(0, 10);
        step(7);
        check("R11 no tick holds", int'(timer_out[0]), 0);
        count_en[0] = 1'b1;
        wait_out(0, 1'b1, 50, n);
        check("R11 tick resume", n, 10);

        // R1 illegal configuration bytes are dropped
        cfg(0, 3, 0, 0);
        load_word(0, 20);
        wr(2'd3, 8'hF6);
        check("R1 channel 3 ignored", int'(timer_out[0]), 0);
        wr(2'd3, 8'h3C);
        wait_out(0, 1'b1, 50, n);
        check("R1 mode 6 ignored", n, 18);

        // R2 reconfiguration stops counting
        cfg(2, 3, 2, 0);
        load_word(2, 50);
        step(5);
        cfg(2, 3, 2, 0);
        lo = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!timer_out[2]) lo++;
        end
        check("R2 halted until load", lo, 0);

        // R7 / R8 random periodic runs
        for (int it = 0; it < 12; it++) begin
            int ch, cnt, md, bcd;
            ch  = int'($urandom_range(0, 2));
            cnt = int'($urandom_range(3, 40));
            bcd = int'($urandom_range(0, 1));
            md  = (it % 2 == 0) ? 2 : 3;
            cfg(ch, 3, md, bcd);
            load_word(ch, bcd ? to_bcd(cnt) : cnt);
            if (md == 2) begin
                wait_out(ch, 1'b0, 100, n);
                check("R7 first low", n, cnt - 1);
                wait_out(ch, 1'b1, 100, n);
                check("R7 low width", n, 1);
                wait_out(ch, 1'b0, 100, n);
                check("R7 period", n, cnt - 1);
            end else begin
                wait_out(ch, 1'b0, 100, n);
                check("R8 high part", n, hi_ticks(cnt));
                wait_out(ch, 1'b1, 100, n);
                check("R8 low part", n, cnt / 2);
                wait_out(ch, 1'b0, 100, n);
                check("R8 next high", n, hi_ticks(cnt));
            end
            cfg(ch, 3, 0, 0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule